// File: doc/BRIEF.md
# Programmable-Priority Interrupt Resolver

This block picks one winner among eight local interrupt sources (six external request lines, a periodic timer and a timer counter) and an external group of eight further requests whose internal logic lives elsewhere. Software sets the ranking of the local sources by writing eight 3-bit rank slots. Each slot names the source that holds that rank. A per-interrupt enable mask gates every request. A 6-bit promotion field can lift any single interrupt number above all others. The block registers the number of the winning interrupt and a valid flag, so its output follows its inputs by one cycle.

A mode bit chooses how the local sources sit against the external group. In grouped placement, every local source outranks every external request. In spread placement, the ranks alternate: local rank 0, external line 0, local rank 1, external line 1, and so on. The mode bit is meant to be set once during bring-up, and the block accepts a change to it only while every interrupt is masked. Interrupt numbers 0 to 7 are the local source codes and numbers 8 to 15 are external lines 0 to 7. Software reaches all state through a word-wide write port and a combinational read port that share one address.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, rank slot k (k = 0..7) holds code k, the promotion field is 0, the mask is all zero, placement is grouped and irq_valid is low.
- R2: Register address 0 holds the rank slots, with slot k in bits [3k+2:3k]. Slot 0 is the highest rank. Among local sources that are pending and enabled, the one in the highest-ranked slot wins.
- R3: When several slots name the same source, the lowest-numbered of those slots sets its rank. Sources named by no slot rank below all named sources, in ascending code order.
- R4: Address 1 bits [5:0] hold the promotion field. When that interrupt number (0..15) is pending and enabled, it wins over every other request. A value of 16 or more promotes nothing.
- R5: A write to the promotion field or to the rank slots takes effect on the first resolution after the write cycle. Promoting the source held in slot 0 leaves the outcome unchanged.
- R6: With address 1 bit 8 clear (grouped), any pending, enabled local source beats every external request, unless a promoted external request is pending.
- R7: With address 1 bit 8 set (spread), local rank r sits at position 2r and external line j at position 2j+1, and the lowest position wins.
- R8: A write to address 1 changes bit 8 only when the mask is all zero at that write. Otherwise the previous placement is kept, while the promotion field is still updated.
- R9: Address 2 bits [15:0] form the mask, where bit n set enables interrupt number n. A disabled request never wins.
- R10: The reserved bits read as zero and writes to them have no effect. These are address 0 bits [31:24], address 1 bits [31:9] and [7:6], address 2 bits [31:16], and all of address 3.
- R11: irq_valid and irq_code are registered and reflect the requests and settings of the previous clock edge. With nothing pending and enabled, irq_valid is 0 and irq_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_req | input | 8 | Local source requests, bit = source code |
| grp_req | input | 8 | External group requests, bit j = interrupt number 8+j |
| irq_valid | output | 1 | A winner exists |
| irq_code | output | 6 | Winning interrupt number, 0 when not valid |

## Verification
The hardest case to reach is a placement change that the block must refuse. Software can only try it while some mask bit is set. The only sign that the refusal worked is the read-back value and a later resolution between local and external requests. The stimulus first sets a single mask bit, writes spread mode, and reads back grouped. It then clears the mask, writes the mode again, and confirms through a spread-sensitive pair of requests that the order between local and external ranks has changed. Duplicate slot names are reached by writing rank slots that repeat codes and then driving mixes of named and unnamed sources.

// File: rtl/irq_prio_pkg.sv
// Package: shared sizes and register addresses of the interrupt resolver.
// Assumes the external group has no more lines than there are local sources.
package irq_prio_pkg;
    localparam int unsigned NUM_SRC_D = 8;   // local sources
    localparam int unsigned NUM_OTH_D = 8;   // external group lines
    localparam int unsigned CODE_W_D  = 3;   // width of one rank slot
    localparam int unsigned HP_W_D    = 6;   // promotion field width
    localparam int unsigned DATA_W_D  = 32;
    localparam int unsigned ADDR_W_D  = 2;

    localparam logic [1:0] ADDR_SLOT = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_MASK = 2'd2;
    localparam int unsigned MODE_BIT = 8;
endpackage

// File: rtl/irq_prio_regs.sv
// Register file: rank slots, promotion field, placement mode and mask.
// Assumes a single-cycle write strobe. The placement bit is accepted only while
// the mask is all zero. Reads are combinational on reg_addr.
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_D,
    parameter int unsigned CODE_W  = CODE_W_D,
    parameter int unsigned NUM_INT = NUM_SRC_D + NUM_OTH_D,
    parameter int unsigned HP_W    = HP_W_D,
    parameter int unsigned DATA_W  = DATA_W_D,
    parameter int unsigned ADDR_W  = ADDR_W_D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    output logic [NUM_SRC*CODE_W-1:0] slot_q,
    output logic [HP_W-1:0]           hp_q,
    output logic                      spread_q,
    output logic [NUM_INT-1:0]        mask_q
);
    localparam int unsigned SLOT_BITS = NUM_SRC * CODE_W;

    logic wr_slot, wr_ctrl, wr_mask;
    assign wr_slot = we && (addr == ADDR_W'(ADDR_SLOT));
    assign wr_ctrl = we && (addr == ADDR_W'(ADDR_CTRL));
    assign wr_mask = we && (addr == ADDR_W'(ADDR_MASK));

    // Rank slots: identity order out of reset, whole field rewritten on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_SRC; k++)
                slot_q[k*CODE_W +: CODE_W] <= CODE_W'(k);
        end else if (wr_slot) begin
            slot_q <= wdata[SLOT_BITS-1:0];
        end
    end

    // Promotion field: free to change at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)       hp_q <= '0;
        else if (wr_ctrl) hp_q <= wdata[HP_W-1:0];
    end

    // Placement mode: taken only while every interrupt is masked.
    always_ff @(posedge clk) begin
        if (!rst_n)                        spread_q <= 1'b0;
        else if (wr_ctrl && mask_q == '0)  spread_q <= wdata[MODE_BIT];
    end

    // Enable mask: one bit per interrupt number.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata[NUM_INT-1:0];
    end

    // Read mux: reserved bits and unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADDR_SLOT): rdata[SLOT_BITS-1:0] = slot_q;
            ADDR_W'(ADDR_CTRL): begin
                rdata[HP_W-1:0]  = hp_q;
                rdata[MODE_BIT]  = spread_q;
            end
            ADDR_W'(ADDR_MASK): rdata[NUM_INT-1:0] = mask_q;
            default:            rdata = '0;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^wdata;
endmodule

// File: rtl/irq_prio_rank.sv
// Rank mapper: turns the rank slots and the placement mode into one position
// per interrupt number (lower wins). Each local source gets a key: the first
// slot that names it, or NUM_SRC+code when it is unnamed. Its compact rank is
// the number of sources with a smaller key. Assumes NUM_OTH <= NUM_SRC.
module irq_prio_rank
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_D,
    parameter int unsigned NUM_OTH = NUM_OTH_D,
    parameter int unsigned CODE_W  = CODE_W_D,
    parameter int unsigned POS_W   = CODE_W_D + 2
) (
    input  logic [NUM_SRC*CODE_W-1:0]           slot_q,
    input  logic                                spread,
    output logic [(NUM_SRC+NUM_OTH)*POS_W-1:0]  pos_vec
);
    localparam int unsigned KEY_W = CODE_W + 1;

    logic [KEY_W-1:0]  key  [NUM_SRC];
    logic [CODE_W-1:0] rank [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        // Key: lowest slot holding this code, else below every slot.
        always_comb begin
            key[s] = KEY_W'(NUM_SRC + s);
            for (int k = NUM_SRC - 1; k >= 0; k--)
                if (slot_q[k*CODE_W +: CODE_W] == CODE_W'(s))
                    key[s] = KEY_W'(k);
        end

        // Compact rank: count sources whose key is smaller.
        always_comb begin
            rank[s] = '0;
            for (int t = 0; t < NUM_SRC; t++)
                if (key[t] < key[s])
                    rank[s] = rank[s] + CODE_W'(1);
        end

        // Position: grouped keeps rank, spread takes even slots.
        always_comb begin
            if (spread) pos_vec[s*POS_W +: POS_W] = POS_W'({rank[s], 1'b0});
            else        pos_vec[s*POS_W +: POS_W] = POS_W'(rank[s]);
        end
    end

    for (genvar j = 0; j < NUM_OTH; j++) begin : g_oth
        // External line: after all locals when grouped, odd slots when spread.
        always_comb begin
            if (spread) pos_vec[(NUM_SRC+j)*POS_W +: POS_W] = POS_W'(2*j + 1);
            else        pos_vec[(NUM_SRC+j)*POS_W +: POS_W] = POS_W'(NUM_SRC + j);
        end
    end
endmodule

// File: rtl/irq_prio_select.sv
// Winner selector: lowest position among active interrupts, with the promoted
// interrupt number taking precedence when it is active. Positions are unique.
module irq_prio_select
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_INT = NUM_SRC_D + NUM_OTH_D,
    parameter int unsigned POS_W   = CODE_W_D + 2,
    parameter int unsigned HP_W    = HP_W_D
) (
    input  logic [NUM_INT-1:0]       active,
    input  logic [NUM_INT*POS_W-1:0] pos_vec,
    input  logic [HP_W-1:0]          hp,
    output logic                     win_valid,
    output logic [HP_W-1:0]          win_code
);
    localparam int unsigned IDX_W = $clog2(NUM_INT);

    logic [POS_W-1:0] best_pos;
    logic [HP_W-1:0]  best_code;
    logic             hp_hit;

    // Linear argmin over positions of active interrupts.
    always_comb begin
        best_pos  = '1;
        best_code = '0;
        win_valid = 1'b0;
        for (int i = 0; i < NUM_INT; i++) begin
            if (active[i] && (!win_valid || pos_vec[i*POS_W +: POS_W] < best_pos)) begin
                best_pos  = pos_vec[i*POS_W +: POS_W];
                best_code = HP_W'(i);
                win_valid = 1'b1;
            end
        end
    end

    // Promotion: an in-range, active promoted number overrides the argmin.
    assign hp_hit   = (hp < HP_W'(NUM_INT)) && active[hp[IDX_W-1:0]];
    assign win_code = hp_hit ? hp : best_code;
endmodule

// File: rtl/irq_prio_resolver.sv
// Top: programmable-priority interrupt resolver. Masks the requests, ranks
// them through the slot registers and placement mode, and registers the winner.
// Assumes requests are synchronous to clk.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_D,
    parameter int unsigned NUM_OTH = NUM_OTH_D,
    parameter int unsigned CODE_W  = CODE_W_D,
    parameter int unsigned HP_W    = HP_W_D,
    parameter int unsigned DATA_W  = DATA_W_D,
    parameter int unsigned ADDR_W  = ADDR_W_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_OTH-1:0] grp_req,
    output logic              irq_valid,
    output logic [HP_W-1:0]   irq_code
);
    localparam int unsigned NUM_INT = NUM_SRC + NUM_OTH;
    localparam int unsigned POS_W   = CODE_W + 2;

    logic [NUM_SRC*CODE_W-1:0] slot_q;
    logic [HP_W-1:0]           hp_q;
    logic                      spread_q;
    logic [NUM_INT-1:0]        mask_q;
    logic [NUM_INT-1:0]        act_vec;
    logic [NUM_INT*POS_W-1:0]  pos_vec;
    logic                      win_valid;
    logic [HP_W-1:0]           win_code;

    irq_prio_regs #(
        .NUM_SRC(NUM_SRC), .CODE_W(CODE_W), .NUM_INT(NUM_INT),
        .HP_W(HP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .slot_q(slot_q),
        .hp_q(hp_q), .spread_q(spread_q), .mask_q(mask_q)
    );

    // Enabled requests, numbered locals first then external lines.
    assign act_vec = {grp_req, src_req} & mask_q;

    irq_prio_rank #(
        .NUM_SRC(NUM_SRC), .NUM_OTH(NUM_OTH), .CODE_W(CODE_W), .POS_W(POS_W)
    ) rank_i (
        .slot_q(slot_q), .spread(spread_q), .pos_vec(pos_vec)
    );

    irq_prio_select #(
        .NUM_INT(NUM_INT), .POS_W(POS_W), .HP_W(HP_W)
    ) sel_i (
        .active(act_vec), .pos_vec(pos_vec), .hp(hp_q),
        .win_valid(win_valid), .win_code(win_code)
    );

    // Output register: one cycle of latency, code forced to zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_code  <= '0;
        end else begin
            irq_valid <= win_valid;
            irq_code  <= win_valid ? win_code : '0;
        end
    end
endmodule

// File: rtl/irq_prio_resolver_chk.sv
// Checker for the resolver, bound to the top. Observes the masked request
// vector, the configuration registers and the registered output.
module irq_prio_resolver_chk #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned NUM_INT = 16,
    parameter int unsigned HP_W    = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned SLOT_BITS = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_INT-1:0] act_vec,
    input logic [HP_W-1:0]   hp_q,
    input logic              spread_q,
    input logic [NUM_INT-1:0] mask_q,
    input logic              irq_valid,
    input logic [HP_W-1:0]   irq_code,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    localparam int unsigned IDX_W = $clog2(NUM_INT);

    logic hp_live;
    assign hp_live = (hp_q < HP_W'(NUM_INT)) && act_vec[hp_q[IDX_W-1:0]];

    // R11
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vec == '0) |=> (!irq_valid && irq_code == '0));

    // R11
    busy_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vec != '0) |=> irq_valid);

    // R4
    promote_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_live |=> (irq_code == $past(hp_q)));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0) |=> (spread_q == $past(spread_q)));

    // R6
    grouped_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spread_q && act_vec[NUM_SRC-1:0] != '0 && !hp_live)
            |=> (irq_code < HP_W'(NUM_SRC)));

    // R10
    slot_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> (reg_rdata[DATA_W-1:SLOT_BITS] == '0));
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(
    .NUM_SRC(NUM_SRC), .NUM_INT(NUM_INT), .HP_W(HP_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_BITS(NUM_SRC*CODE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .act_vec(act_vec), .hp_q(hp_q),
    .spread_q(spread_q), .mask_q(mask_q), .irq_valid(irq_valid),
    .irq_code(irq_code), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/irq_prio_resolver_tb.sv
// Directed bench for the resolver. A shadow of the configuration is kept from
// the bench's own writes, and expected winners come from an ordered-list model.
module irq_prio_resolver_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  src_req = '0;
    logic [7:0]  grp_req = '0;
    logic        irq_valid;
    logic [5:0]  irq_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [2:0]  sh_slot [8];
    logic [5:0]  sh_hp;
    logic        sh_spread;
    logic [15:0] sh_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .grp_req(grp_req), .irq_valid(irq_valid), .irq_code(irq_code)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_slots(input int s0, s1, s2, s3, s4, s5, s6, s7);
        int v[8] = '{s0, s1, s2, s3, s4, s5, s6, s7};
        logic [31:0] w = '0;
        for (int k = 0; k < 8; k++) w[3*k +: 3] = 3'(v[k]);
        return w;
    endfunction

    function automatic logic [31:0] shadow_read(input logic [1:0] a);
        logic [31:0] w = '0;
        case (a)
            2'd0: for (int k = 0; k < 8; k++) w[3*k +: 3] = sh_slot[k];
            2'd1: begin w[5:0] = sh_hp; w[8] = sh_spread; end
            2'd2: w[15:0] = sh_mask;
            default: w = '0;
        endcase
        return w;
    endfunction

    // Expected winner from an explicit ordered list of interrupt numbers.
    task automatic expect_win(input logic [15:0] act, output logic v, output logic [5:0] code);
        int  order[8];
        int  list[16];
        bit  used[8] = '{default: 0};
        int  n = 0;
        for (int k = 0; k < 8; k++)
            if (!used[sh_slot[k]]) begin order[n] = int'(sh_slot[k]); used[sh_slot[k]] = 1; n++; end
        for (int c = 0; c < 8; c++)
            if (!used[c]) begin order[n] = c; n++; end
        for (int i = 0; i < 8; i++) begin
            if (sh_spread) begin list[2*i] = order[i]; list[2*i+1] = 8 + i; end
            else           begin list[i] = order[i];   list[8+i] = 8 + i;   end
        end
        v = 1'b0; code = '0;
        if (sh_hp < 6'd16 && act[sh_hp[3:0]]) begin v = 1'b1; code = sh_hp; end
        else
            for (int i = 0; i < 16; i++)
                if (!v && act[list[i]]) begin v = 1'b1; code = 6'(list[i]); end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        case (a)
            2'd0: for (int k = 0; k < 8; k++) sh_slot[k] = d[3*k +: 3];
            2'd1: begin sh_hp = d[5:0]; if (sh_mask == '0) sh_spread = d[8]; end
            2'd2: sh_mask = d[15:0];
            default: ;
        endcase
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_check(string req, input logic [1:0] a);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, shadow_read(a));
    endtask

    task automatic resolve(string req, input logic [7:0] s, input logic [7:0] g);
        logic v; logic [5:0] c;
        @(negedge clk);
        src_req = s; grp_req = g;
        expect_win({g, s} & sh_mask, v, c);
        @(negedge clk);
        check({req, " valid"}, 32'(irq_valid), 32'(v));
        check({req, " code"}, 32'(irq_code), 32'(c));
    endtask

    task automatic t_reset;
        for (int k = 0; k < 8; k++) sh_slot[k] = 3'(k);
        sh_hp = '0; sh_spread = 1'b0; sh_mask = '0;
        for (int a = 0; a < 4; a++) reg_check("R1 reset reg", 2'(a));
        check("R1 reset slots", reg_rdata & 0, 0);
        reg_check("R1 slot identity", 2'd0);
        check("R1 identity value", reg_rdata, 32'h00FAC688);
        check("R1 valid low", 32'(irq_valid), 0);
        resolve("R9 all masked", 8'hFF, 8'hFF);
    endtask

    task automatic t_mode_gate;
        reg_write(2'd2, 32'h0000_0001);
        reg_write(2'd1, 32'h0000_0100);
        reg_check("R8 refused mode", 2'd1);
        check("R8 mode still grouped", 32'(reg_rdata[8]), 0);
        reg_write(2'd1, 32'h0000_0000);
        reg_write(2'd2, 32'h0000_0000);
        reg_write(2'd1, 32'h0000_0100);
        reg_check("R8 accepted mode", 2'd1);
        check("R8 mode spread", 32'(reg_rdata[8]), 1);
        reg_write(2'd1, 32'h0000_0000);
        reg_write(2'd2, 32'h0000_FFFF);
    endtask

    task automatic t_order;
        logic v; logic [5:0] c;
        resolve("R11 idle", 8'h00, 8'h00);
        @(negedge clk);
        src_req = 8'h01;
        #1;
        check("R11 latency still idle", 32'(irq_valid), 0);
        @(negedge clk);
        check("R11 valid after one edge", 32'(irq_valid), 1);
        resolve("R2 identity mix", 8'hA4, 8'h00);
        resolve("R2 lowest only", 8'h80, 8'h00);
        reg_write(2'd0, pack_slots(7, 6, 5, 4, 3, 2, 1, 0));
        resolve("R2 reversed", 8'h05, 8'h00);
        reg_write(2'd0, pack_slots(5, 2, 7, 0, 1, 3, 6, 4));
        resolve("R2 shuffled", 8'h95, 8'h00);
        resolve("R2 shuffled low", 8'h13, 8'h00);
        expect_win(16'h0013, v, c);
        check("R2 model sanity", 32'(c), 32'd0);
    endtask

    task automatic t_dup;
        reg_write(2'd0, pack_slots(3, 3, 1, 1, 6, 6, 6, 6));
        resolve("R3 dup named first", 8'h4A, 8'h00);
        resolve("R3 dup named last", 8'h40 | 8'h35, 8'h00);
        resolve("R3 unnamed ascending", 8'hB4, 8'h00);
        resolve("R3 unnamed top", 8'h80, 8'h00);
    endtask

    task automatic t_promote;
        reg_write(2'd0, pack_slots(0, 1, 2, 3, 4, 5, 6, 7));
        reg_write(2'd1, 32'h0000_0005);
        resolve("R4 promote local", 8'h21, 8'h00);
        resolve("R4 promoted idle", 8'h03, 8'h00);
        reg_write(2'd1, 32'h0000_000C);
        resolve("R4 promote external", 8'h01, 8'h10);
        reg_write(2'd1, 32'h0000_0028);
        resolve("R4 out of range", 8'h06, 8'hFF);
        reg_write(2'd0, pack_slots(4, 0, 1, 2, 3, 5, 6, 7));
        reg_write(2'd1, 32'h0000_0004);
        resolve("R5 promote slot0", 8'h13, 8'h00);
        reg_write(2'd1, 32'h0000_0001);
        resolve("R5 next resolution", 8'h13, 8'h00);
        reg_write(2'd1, 32'h0000_0030);
    endtask

    task automatic t_place;
        reg_write(2'd0, pack_slots(0, 1, 2, 3, 4, 5, 6, 7));
        resolve("R6 grouped local wins", 8'h08, 8'h04);
        resolve("R6 external only", 8'h00, 8'h06);
        reg_write(2'd2, 32'h0);
        reg_write(2'd1, 32'h0000_0130);
        reg_write(2'd2, 32'h0000_FFFF);
        resolve("R7 spread external wins", 8'h08, 8'h04);
        resolve("R7 spread local wins", 8'h02, 8'h04);
        resolve("R7 spread tie pair", 8'h04, 8'h06);
        reg_write(2'd2, 32'h0);
        reg_write(2'd1, 32'h0000_0030);
        reg_write(2'd2, 32'h0000_FFFF);
    endtask

    task automatic t_mask;
        reg_write(2'd2, 32'h0000_FFFE);
        resolve("R9 masked source skipped", 8'h03, 8'h00);
        reg_write(2'd2, 32'h0000_00FF);
        resolve("R9 external masked", 8'h00, 8'hFF);
        reg_write(2'd2, 32'h0000_FFFF);
    endtask

    task automatic t_reserved;
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_check("R10 slot reserved", 2'd0);
        check("R10 slot value", reg_rdata, 32'h00FF_FFFF);
        reg_write(2'd1, 32'hFFFF_FEC3);
        reg_check("R10 ctrl reserved", 2'd1);
        check("R10 ctrl value", reg_rdata, 32'h0000_0003);
        reg_write(2'd2, 32'hFFFF_FFFF);
        reg_check("R10 mask reserved", 2'd2);
        reg_write(2'd3, 32'hFFFF_FFFF);
        reg_check("R10 unmapped", 2'd3);
        check("R10 unmapped zero", reg_rdata, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_mode_gate;
        t_order;
        t_dup;
        t_promote;
        t_place;
        t_mask;
        t_reserved;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule